// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block makes the clock waveform and the bus-condition timing for an I2C master. A byte engine asks for one bus condition at a time: start, repeated start, stop, or a single data bit. The generator drives the open-drain enables for SCL and SDA and reads SCL back so that it can follow a slave that stretches the clock. A prescaler divides the peripheral clock by eight. Two separate divider fields then set the length of the high phase and of the low phase, so the low time can be made longer than the high time.

Each request arrives over a valid/ready handshake. `cmd_ready` is high only when the generator is idle or holding SCL low between conditions, and only while `run_en` is high. A request is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The requester may hold `cmd_valid` high for as long as it likes, and nothing is taken while `cmd_ready` is low. `done` pulses when a taken condition has finished. Two strobes tell the byte engine when SDA may change (`chg_stb`) and when the slave's bit is stable (`smp_stb`).

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, SCL and SDA are both released (`scl_oe`=0, `sda_oe`=0), no strobe, `done` or `stretch` is asserted, and `cmd_ready` follows `run_en`.
- R2: A START (`cmd_op`=0) taken while idle drives SDA low in the next cycle, drives SCL low 8×(H+1) cycles later, and latches the high divider H and the low divider L.
- R3: Every low phase holds SCL driven low for exactly 8×(L+1) cycles, counted from the cycle after the request is taken.
- R4: After a low phase, SCL is released, and the high count of 8×(H+1) cycles starts only in the cycle after SCL reads back high.
- R5: `chg_stb` is high for one cycle, at low-phase cycle 4×(L+1). SDA takes its new value in the next cycle. A BIT (`cmd_op`=3) with `cmd_bit`=0 drives SDA low, and one with `cmd_bit`=1 releases it.
- R6: `smp_stb` is high for one cycle, in the last cycle of a data high phase.
- R7: While SCL is released but reads low, `stretch` is high and the generator waits without a time limit.
- R8: A RESTART (`cmd_op`=1), or a START taken while SCL is held, releases SDA at mid-low. Once SCL reads high, SDA is driven low 7×(H+1) cycles later and SCL is driven low 16×(H+1) cycles later.
- R9: A STOP (`cmd_op`=2) drives SDA low at mid-low. After the high count it releases SDA. It then keeps the bus idle for 8×(L+1) cycles before returning to idle.
- R10: `done` is a one-cycle pulse in the first cycle after a condition has finished. `cmd_ready` is low from the cycle after a request is taken until that pulse.
- R11: A change to `div_hi` or `div_lo` after a START is taken has no effect until the next START taken from idle.
- R12: A BIT, STOP or RESTART taken while idle is consumed with no change on the bus and no `done`.
- R13: While `run_en` is low no request is taken, even with `cmd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Allows requests to be taken |
| div_hi | input | DW | High-phase divider H |
| div_lo | input | DW | Low-phase divider L |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request can be taken |
| cmd_op | input | 2 | 0 START, 1 RESTART, 2 STOP, 3 BIT |
| cmd_bit | input | 1 | Data value for a BIT request |
| scl_in | input | 1 | SCL line level read back |
| scl_oe | output | 1 | 1 drives SCL low |
| sda_oe | output | 1 | 1 drives SDA low |
| chg_stb | output | 1 | SDA may change (mid-low) |
| smp_stb | output | 1 | SDA is stable for sampling (end of high) |
| done | output | 1 | Condition finished |
| stretch | output | 1 | SCL held low by a slave |

## Verification
The bench goes after these corner cases:
- Divider fields of zero. A design that counted raw clocks instead of prescaled units would end those phases early.
- A slave that stretches for many cycles. A design that counted during the hold would shorten the high phase.
- A stretch of zero length. A design that started counting before SCL reads back high would let the rise time eat into the high phase.
- A divider change in the middle of a transfer. A design that did not latch the fields would change the bit timing at once.
- Repeated-start and stop sequences. A wrong 7/8 point or bus-idle count shifts the SDA edge against the reference, cycle by cycle.
- Requests that are invalid while idle. A design that acted on them would pulse `done` or move SDA.

// File: rtl/scl_tmr_pkg.sv
package scl_tmr_pkg;

  // Bus condition requested by the byte engine
  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_STOP    = 2'd2,
    OP_BIT     = 2'd3
  } cond_op_e;

  // Timing phases of the generator
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HELD,
    ST_LOW,
    ST_WAIT_HI,
    ST_HIGH,
    ST_RS_HIGH,
    ST_SP_HIGH,
    ST_BUS_FREE
  } phase_st_e;

  // What follows the low phase of an accepted condition
  typedef enum logic [1:0] {
    K_DATA,
    K_RSTART,
    K_STOP
  } xfer_kind_e;

endpackage

// File: rtl/scl_tmr_counter.sv
// Phase timer: a 3-bit prescaler (divide by eight) feeding a unit counter.
module scl_tmr_counter #(
  parameter int UW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [UW-1:0] lim,
  output logic          term,
  output logic [UW+2:0] cyc
);
  localparam int PW = 3;
  localparam logic [PW-1:0] PRE_LAST = {PW{1'b1}};

  logic [PW-1:0] pre;
  logic [UW-1:0] unit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      unit <= '0;
    end else if (clr) begin
      pre  <= '0;
      unit <= '0;
    end else if (en) begin
      if (pre == PRE_LAST) begin
        pre  <= '0;
        unit <= unit + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign term = (pre == PRE_LAST) && (unit == lim);
  assign cyc  = {unit, pre};
endmodule

// File: rtl/scl_tmr_limits.sv
// Derives the phase limits and compare points from the latched dividers.
module scl_tmr_limits #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] hi_div,
  input  logic [DW-1:0] lo_div,
  output logic [DW:0]   hi_lim,
  output logic [DW:0]   lo_lim,
  output logic [DW:0]   rs_lim,
  output logic [DW+3:0] mid_cyc,
  output logic [DW+3:0] rs_fall_cyc
);
  localparam int CW = DW + 4;

  logic [CW-1:0] lo_p1;

  assign hi_lim = {1'b0, hi_div};
  assign lo_lim = {1'b0, lo_div};
  // twice the high time: 2*(H+1) units, limit 2H+1
  assign rs_lim = {hi_div, 1'b1};
  // middle of low: 4*(L+1) cycles
  assign lo_p1   = {4'b0000, lo_div} + {{(CW-1){1'b0}}, 1'b1};
  assign mid_cyc = {lo_p1[CW-3:0], 2'b00};
  // seven eighths of high time, minus one for the register stage: 7*(H+1)-1
  assign rs_fall_cyc = {1'b0, hi_div, 3'b000} - {4'b0000, hi_div}
                     + {{(CW-3){1'b0}}, 3'd6};
endmodule

// File: rtl/scl_tmr_ctrl.sv
// Condition sequencer: phase state machine, line enables, strobes.
module scl_tmr_ctrl
  import scl_tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [DW-1:0] div_hi,
  input  logic [DW-1:0] div_lo,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          chg_stb,
  output logic          smp_stb,
  output logic          done,
  output logic          stretch,
  output logic [DW-1:0] hi_q,
  output logic [DW-1:0] lo_q,
  input  logic [DW:0]   hi_lim,
  input  logic [DW:0]   lo_lim,
  input  logic [DW:0]   rs_lim,
  input  logic [DW+3:0] mid_cyc,
  input  logic [DW+3:0] rs_fall_cyc,
  input  logic          tmr_term,
  input  logic [DW+3:0] tmr_cyc,
  output logic          tmr_clr,
  output logic          tmr_en,
  output logic [DW:0]   tmr_lim
);
  phase_st_e  st, nxt;
  xfer_kind_e kind;
  cond_op_e   op;
  logic       drv_sda;
  logic       scl_q, sda_q, done_q;
  logic [DW-1:0] hi_r, lo_r;
  logic       accept;

  assign op        = cond_op_e'(cmd_op);
  assign cmd_ready = run_en && ((st == ST_IDLE) || (st == ST_HELD));
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    nxt     = st;
    tmr_en  = 1'b0;
    tmr_lim = lo_lim;
    case (st)
      ST_IDLE:    if (accept && (op == OP_START)) nxt = ST_SETUP;
      ST_SETUP: begin
        tmr_en  = 1'b1;
        tmr_lim = hi_lim;
        if (tmr_term) nxt = ST_HELD;
      end
      ST_HELD:    if (accept) nxt = ST_LOW;
      ST_LOW: begin
        tmr_en = 1'b1;
        if (tmr_term) nxt = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (scl_in) begin
          case (kind)
            K_DATA:   nxt = ST_HIGH;
            K_RSTART: nxt = ST_RS_HIGH;
            default:  nxt = ST_SP_HIGH;
          endcase
        end
      end
      ST_HIGH: begin
        tmr_en  = 1'b1;
        tmr_lim = hi_lim;
        if (tmr_term) nxt = ST_HELD;
      end
      ST_RS_HIGH: begin
        tmr_en  = 1'b1;
        tmr_lim = rs_lim;
        if (tmr_term) nxt = ST_HELD;
      end
      ST_SP_HIGH: begin
        tmr_en  = 1'b1;
        tmr_lim = hi_lim;
        if (tmr_term) nxt = ST_BUS_FREE;
      end
      ST_BUS_FREE: begin
        tmr_en = 1'b1;
        if (tmr_term) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign tmr_clr = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      kind    <= K_DATA;
      drv_sda <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      hi_r    <= '0;
      lo_r    <= '0;
    end else begin
      st     <= nxt;
      done_q <= (nxt != st) && ((nxt == ST_HELD) || (nxt == ST_IDLE));
      if ((st == ST_IDLE) && accept && (op == OP_START)) begin
        hi_r  <= div_hi;
        lo_r  <= div_lo;
        sda_q <= 1'b1;
      end
      if ((st == ST_HELD) && accept) begin
        case (op)
          OP_BIT: begin
            kind    <= K_DATA;
            drv_sda <= !cmd_bit;
          end
          OP_STOP: begin
            kind    <= K_STOP;
            drv_sda <= 1'b1;
          end
          default: begin
            kind    <= K_RSTART;
            drv_sda <= 1'b0;
          end
        endcase
      end
      if ((st == ST_LOW) && (tmr_cyc == mid_cyc)) sda_q <= drv_sda;
      if ((st == ST_LOW) && tmr_term) scl_q <= 1'b0;
      if ((nxt == ST_HELD) && (st != ST_HELD)) scl_q <= 1'b1;
      if ((st == ST_RS_HIGH) && (tmr_cyc == rs_fall_cyc)) sda_q <= 1'b1;
      if ((st == ST_SP_HIGH) && tmr_term) sda_q <= 1'b0;
    end
  end

  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;
  assign done    = done_q;
  assign hi_q    = hi_r;
  assign lo_q    = lo_r;
  assign chg_stb = (st == ST_LOW) && (tmr_cyc == mid_cyc);
  assign smp_stb = (st == ST_HIGH) && tmr_term;
  assign stretch = (st == ST_WAIT_HI) && !scl_in;
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [DW-1:0] div_hi,
  input  logic [DW-1:0] div_lo,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_bit,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          chg_stb,
  output logic          smp_stb,
  output logic          done,
  output logic          stretch
);
  localparam int UW = DW + 1;
  localparam int CW = UW + 3;

  logic [DW-1:0] hi_q, lo_q;
  logic [DW:0]   hi_lim, lo_lim, rs_lim, tmr_lim;
  logic [CW-1:0] mid_cyc, rs_fall_cyc, tmr_cyc;
  logic          tmr_term, tmr_clr, tmr_en;

  scl_tmr_limits #(.DW(DW)) u_lim (
    .hi_div(hi_q), .lo_div(lo_q),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .rs_lim(rs_lim),
    .mid_cyc(mid_cyc), .rs_fall_cyc(rs_fall_cyc)
  );

  scl_tmr_counter #(.UW(UW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en),
    .lim(tmr_lim), .term(tmr_term), .cyc(tmr_cyc)
  );

  scl_tmr_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .div_hi(div_hi), .div_lo(div_lo),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .scl_in(scl_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .chg_stb(chg_stb),
    .smp_stb(smp_stb), .done(done), .stretch(stretch),
    .hi_q(hi_q), .lo_q(lo_q),
    .hi_lim(hi_lim), .lo_lim(lo_lim), .rs_lim(rs_lim),
    .mid_cyc(mid_cyc), .rs_fall_cyc(rs_fall_cyc),
    .tmr_term(tmr_term), .tmr_cyc(tmr_cyc),
    .tmr_clr(tmr_clr), .tmr_en(tmr_en), .tmr_lim(tmr_lim)
  );
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic cmd_ready,
  input logic scl_in,
  input logic scl_oe,
  input logic sda_oe,
  input logic chg_stb,
  input logic smp_stb,
  input logic done,
  input logic stretch
);
  // R5: data change is only announced while SCL is driven low
  a_r5_chg_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> scl_oe);

  // R6: sampling happens with SCL released and reading high
  a_r6_smp_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (!scl_oe && scl_in));

  // R7: a stretch is only reported while the generator has released SCL
  a_r7_stretch_released: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |-> !scl_oe);

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: on completion the generator is again able to take a request
  a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready == run_en));

  // R4: strobes are never coincident
  a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_stb && smp_stb));

  // R9: SDA released while SCL is released marks a stop; no strobe then
  a_r9_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe) |-> !smp_stb);
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmd_ready(cmd_ready),
  .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .chg_stb(chg_stb),
  .smp_stb(smp_stb), .done(done), .stretch(stretch)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, run_en, cmd_valid, cmd_bit, hold;
  logic [1:0] cmd_op;
  logic [DW-1:0] div_hi, div_lo;
  logic cmd_ready, scl_oe, sda_oe, chg_stb, smp_stb, done, stretch, scl_in;

  // open-drain SCL: low if the master drives it or the slave holds it
  assign scl_in = !scl_oe && !hold;

  scl_timing_gen #(.DW(DW)) i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .div_hi(div_hi), .div_lo(div_lo),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .scl_in(scl_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .chg_stb(chg_stb),
    .smp_stb(smp_stb), .done(done), .stretch(stretch)
  );

  int total = 0;
  int bad = 0;
  bit keep_valid = 1'b0;
  logic e_scl, e_sda, e_chg, e_smp, e_done, e_str, e_rdy;
  int m_h, m_l;
  logic m_sda, m_held;
  string req;

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // compare every output once per clock, away from the active edge
  task automatic tick();
    @(negedge clk);
    total++;
    if ({scl_oe, sda_oe, chg_stb, smp_stb, done, stretch, cmd_ready} !==
        {e_scl, e_sda, e_chg, e_smp, e_done, e_str, e_rdy}) begin
      bad++;
      $display("FAIL %s t=%0t: got scl=%b sda=%b chg=%b smp=%b done=%b str=%b rdy=%b exp scl=%b sda=%b chg=%b smp=%b done=%b str=%b rdy=%b",
               req, $time, scl_oe, sda_oe, chg_stb, smp_stb, done, stretch, cmd_ready,
               e_scl, e_sda, e_chg, e_smp, e_done, e_str, e_rdy);
    end
    if (!keep_valid) cmd_valid = 1'b0;
  endtask

  task automatic seg(string r, int n, logic scl, logic s0, logic s1, int sw, int chg, int smp);
    for (int i = 0; i < n; i++) begin
      req = r; e_scl = scl; e_sda = (i >= sw) ? s1 : s0;
      e_chg = (i == chg); e_smp = (i == smp);
      e_str = 1'b0; e_done = 1'b0; e_rdy = 1'b0;
      tick();
    end
  endtask

  task automatic wait_hi(string r, int s);
    for (int k = 0; k < ((s > 0) ? s : 1); k++) begin
      hold = (k < s);
      req = r; e_scl = 1'b0; e_sda = m_sda; e_chg = 1'b0; e_smp = 1'b0;
      e_str = (k < s); e_done = 1'b0; e_rdy = 1'b0;
      tick();
    end
    hold = 1'b0;
  endtask

  task automatic fin(string r);
    req = r; e_scl = m_held; e_sda = m_sda; e_chg = 1'b0; e_smp = 1'b0;
    e_str = 1'b0; e_done = 1'b1; e_rdy = run_en;
    tick();
    e_done = 1'b0;
  endtask

  task automatic idle(string r, int n);
    for (int i = 0; i < n; i++) begin
      req = r; e_scl = m_held; e_sda = m_sda; e_chg = 1'b0; e_smp = 1'b0;
      e_str = 1'b0; e_done = 1'b0; e_rdy = run_en;
      tick();
    end
  endtask

  task automatic issue(logic [1:0] op, logic b);
    cmd_op = op; cmd_bit = b; cmd_valid = 1'b1;
  endtask

  task automatic low(string r, logic drv);
    seg(r, 8 * (m_l + 1), 1'b1, m_sda, drv, 4 * (m_l + 1) + 1, 4 * (m_l + 1), -1);
    m_sda = drv;
  endtask

  task automatic c_restart(logic [1:0] op, int s);
    issue(op, 1'b0);
    low("R8,R3", 1'b0);
    wait_hi("R8,R7", s);
    seg("R8", 16 * (m_h + 1), 1'b0, 1'b0, 1'b1, 7 * (m_h + 1), -1, -1);
    m_sda = 1'b1;
    fin("R8,R10");
  endtask

  task automatic c_start(string r);
    if (!m_held) begin
      m_h = int'(div_hi); m_l = int'(div_lo);
      issue(2'd0, 1'b0);
      m_sda = 1'b1;
      seg(r, 8 * (m_h + 1), 1'b0, 1'b1, 1'b1, 0, -1, -1);
      m_held = 1'b1;
      fin(r);
    end else begin
      c_restart(2'd0, 0);
    end
  endtask

  task automatic c_bit(logic b, int s, string r);
    issue(2'd3, b);
    low(r, !b);
    wait_hi("R7,R4", s);
    seg("R4,R6", 8 * (m_h + 1), 1'b0, m_sda, m_sda, 0, -1, 8 * (m_h + 1) - 1);
    fin("R10");
  endtask

  task automatic c_stop(int s);
    issue(2'd2, 1'b0);
    low("R9,R3", 1'b1);
    wait_hi("R9,R7", s);
    seg("R9", 8 * (m_h + 1), 1'b0, 1'b1, 1'b1, 0, -1, -1);
    seg("R9", 8 * (m_l + 1), 1'b0, 1'b0, 1'b0, 0, -1, -1);
    m_sda = 1'b0; m_held = 1'b0;
    fin("R9,R10");
  endtask

  task automatic ignored(logic [1:0] op);
    issue(op, 1'b1);
    idle("R12", 3);
  endtask

  initial begin
    rst_n = 1'b0; run_en = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_bit = 1'b0;
    hold = 1'b0; div_hi = 8'd1; div_lo = 8'd2;
    m_held = 1'b0; m_sda = 1'b0; m_h = 0; m_l = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 3);

    // first transfer with H=1, L=2
    c_start("R2");
    c_bit(1'b0, 0, "R3,R5");
    c_bit(1'b1, 0, "R3,R5");
    c_bit(1'b1, 5, "R7,R5");
    // R11: new divider values must not affect the running transfer
    div_hi = 8'd3; div_lo = 8'd0;
    idle("R11", 2);
    c_bit(1'b0, 0, "R11,R3");
    c_restart(2'd1, 0);
    c_start("R8");
    c_bit(1'b1, 2, "R5,R7");
    c_stop(0);
    idle("R9", 2);

    // requests that make no sense while idle
    ignored(2'd3);
    ignored(2'd2);
    ignored(2'd1);

    // next START picks up H=3, L=0
    c_start("R11,R2");
    c_bit(1'b0, 40, "R11,R3");
    c_bit(1'b1, 0, "R11,R5");
    c_stop(3);

    // R13: run enable low blocks acceptance
    run_en = 1'b0;
    keep_valid = 1'b1;
    issue(2'd0, 1'b0);
    idle("R13", 6);
    keep_valid = 1'b0;
    cmd_valid = 1'b0;
    run_en = 1'b1;
    idle("R13", 2);

    // smallest dividers
    div_hi = 8'd0; div_lo = 8'd0;
    c_start("R2");
    c_bit(1'b0, 1, "R3,R5");
    c_restart(2'd1, 0);
    c_bit(1'b1, 0, "R5");
    c_stop(0);
    idle("R1", 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule